// File: doc/BRIEF.md
# Event-Driven Timer Output Latch

This block holds the output levels of a multi-output timer/PWM unit. Each output is one flip-flop. While any counter runs, decoded timer events change the outputs: a set strobe drives an output high, a clear strobe drives it low, and a toggle strobe inverts it. Software may also load every output at once through a simple write port. The load is accepted only when all active counters are halted. A rejected load leaves the outputs unchanged and raises a one-cycle reject pulse.

The unify configuration bit selects which halt flags are checked. With unify at 1, the unified counter's halt flag alone decides. With unify at 0, the low and the high counter must both be halted. The read port shows the present output levels at any time, with the unused upper bits at zero.

Top module: `evt_out_reg`

## Requirements
- R1: After reset, every output level is 0, the read data is 0 and the reject pulse is 0.
- R2: With unify = 0, a write while both the low-counter and the high-counter halt flags are 1 loads bit n of the write data into output n at the next clock edge, for n = 0..5.
- R3: With unify = 1, a write while the unified halt flag is 1 loads the outputs from write data bits 5:0, whatever the low and high halt flags are.
- R4: A write that is not permitted (unify = 0 with either the low or the high halt flag at 0, or unify = 1 with the unified halt flag at 0) leaves the outputs unchanged by the write. The reject output is then 1 for exactly the one cycle after that edge.
- R5: With no permitted write, a set strobe alone drives its output to 1 and a clear strobe alone drives it to 0 at the next edge. An output with no strobe keeps its level.
- R6: With no permitted write, an output inverts at the next edge when its toggle strobe is 1, or when its set and clear strobes are both 1. A toggle strobe takes priority over a lone set or clear strobe.
- R7: On a cycle where a write is permitted, all event strobes are ignored and the outputs take the written value.
- R8: The read data always equals the present output levels in bits 5:0, with bits 31:6 at zero.
- R9: Event strobes arriving in the same cycle as a rejected write still act on the outputs as described in R5 and R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_stb | input | 6 | Per-output set event strobes |
| clr_stb | input | 6 | Per-output clear event strobes |
| tgl_stb | input | 6 | Per-output toggle event strobes |
| halt_lo | input | 1 | Low counter halted |
| halt_hi | input | 1 | High counter halted |
| halt_uni | input | 1 | Unified counter halted |
| unify | input | 1 | 1 = single unified counter, 0 = split low/high counters |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Present output levels, zero-extended |
| out_lvl | output | 6 | Output levels |
| wr_reject | output | 1 | One-cycle pulse after a rejected write |

## Verification
Output levels and the reject pulse are both registered. Each is due one clock edge after the cycle that carried the strobe or the write. The read data is combinational and is due in the same cycle as the levels it mirrors. The bench applies stimulus at the falling edge and computes the expected next state from the requirements. It compares levels, reject pulse and read data at the following falling edge, half a cycle after the edge that should have produced them.

// File: rtl/evt_out_pkg.sv
package evt_out_pkg;

   // Action applied to one output flip-flop in a cycle
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_SET  = 2'd1,
      ACT_CLR  = 2'd2,
      ACT_FLIP = 2'd3
   } evt_act_e;

   // Event resolution: a toggle request (explicit or set+clear) outranks set/clear
   function automatic evt_act_e resolve_evt(input logic s, input logic c, input logic t);
      if (t || (s && c)) return ACT_FLIP;
      else if (s)        return ACT_SET;
      else if (c)        return ACT_CLR;
      else               return ACT_HOLD;
   endfunction

endpackage

// File: rtl/evt_out_permit.sv
module evt_out_permit (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  logic halt_lo,
   input  logic halt_hi,
   input  logic halt_uni,
   input  logic unify,
   output logic sw_load,
   output logic reject_q
);
   logic all_halted;

   always_comb begin
      if (unify) all_halted = halt_uni;
      else       all_halted = halt_lo & halt_hi;
   end

   assign sw_load = wr_en & all_halted;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) reject_q <= 1'b0;
      else        reject_q <= wr_en & ~all_halted;
   end
endmodule

// File: rtl/evt_out_cell.sv
module evt_out_cell
   import evt_out_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sw_load,
   input  logic sw_val,
   input  logic set_i,
   input  logic clr_i,
   input  logic tgl_i,
   output logic q
);
   evt_act_e act;

   assign act = resolve_evt(set_i, clr_i, tgl_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (sw_load) begin
         q <= sw_val;
      end else begin
         unique case (act)
            ACT_SET:  q <= 1'b1;
            ACT_CLR:  q <= 1'b0;
            ACT_FLIP: q <= ~q;
            default:  q <= q;
         endcase
      end
   end
endmodule

// File: rtl/evt_out_rdmux.sv
module evt_out_rdmux #(
   parameter int NUM_OUT = 6,
   parameter int DATA_W  = 32
) (
   input  logic [NUM_OUT-1:0] lvl,
   output logic [DATA_W-1:0]  rd_data
);
   localparam int PAD_W = DATA_W - NUM_OUT;

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, lvl};
      end else begin : g_nopad
         assign rd_data = lvl;
      end
   endgenerate
endmodule

// File: rtl/evt_out_reg.sv
module evt_out_reg #(
   parameter int NUM_OUT = 6,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OUT-1:0] set_stb,
   input  logic [NUM_OUT-1:0] clr_stb,
   input  logic [NUM_OUT-1:0] tgl_stb,
   input  logic               halt_lo,
   input  logic               halt_hi,
   input  logic               halt_uni,
   input  logic               unify,
   input  logic               wr_en,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic [NUM_OUT-1:0] out_lvl,
   output logic               wr_reject
);
   initial begin
      if (NUM_OUT < 1 || NUM_OUT > DATA_W)
         $error("evt_out_reg: NUM_OUT must lie in 1..DATA_W");
      if (DATA_W < 1)
         $error("evt_out_reg: DATA_W must be positive");
   end

   logic sw_load;

   evt_out_permit u_permit (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .halt_lo  (halt_lo),
      .halt_hi  (halt_hi),
      .halt_uni (halt_uni),
      .unify    (unify),
      .sw_load  (sw_load),
      .reject_q (wr_reject)
   );

   generate
      for (genvar i = 0; i < NUM_OUT; i++) begin : g_cell
         evt_out_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .sw_load (sw_load),
            .sw_val  (wr_data[i]),
            .set_i   (set_stb[i]),
            .clr_i   (clr_stb[i]),
            .tgl_i   (tgl_stb[i]),
            .q       (out_lvl[i])
         );
      end
   endgenerate

   evt_out_rdmux #(.NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_rdmux (
      .lvl     (out_lvl),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/evt_out_reg_chk.sv
module evt_out_reg_chk #(
   parameter int NUM_OUT = 6,
   parameter int DATA_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_OUT-1:0] set_stb,
   input logic [NUM_OUT-1:0] clr_stb,
   input logic [NUM_OUT-1:0] tgl_stb,
   input logic               halt_lo,
   input logic               halt_hi,
   input logic               halt_uni,
   input logic               unify,
   input logic               wr_en,
   input logic [DATA_W-1:0]  wr_data,
   input logic [DATA_W-1:0]  rd_data,
   input logic [NUM_OUT-1:0] out_lvl,
   input logic               wr_reject
);
   logic split_ok, uni_ok, no_evt;
   assign split_ok = !unify && halt_lo && halt_hi;
   assign uni_ok   = unify && halt_uni;
   assign no_evt   = (set_stb == '0) && (clr_stb == '0) && (tgl_stb == '0);

   // R8: read data mirrors levels, zero above
   assert_rd_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data == DATA_W'(out_lvl));

   // R2 and R7: split-mode write loads, strobes ignored
   assert_split_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && split_ok) |=> out_lvl == $past(wr_data[NUM_OUT-1:0]));

   // R3
   assert_uni_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && uni_ok) |=> out_lvl == $past(wr_data[NUM_OUT-1:0]));

   // R4: blocked write without events leaves levels and pulses reject
   assert_block_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !split_ok && !uni_ok && no_evt) |=> ($stable(out_lvl) && wr_reject));

   // R4: reject only follows a write
   assert_reject_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> $past(wr_en));

   // R5: idle cycle keeps levels
   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && no_evt) |=> $stable(out_lvl));

   // R6: all toggles invert every output
   assert_all_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && (&tgl_stb)) |=> out_lvl == ~$past(out_lvl));
endmodule

bind evt_out_reg evt_out_reg_chk #(.NUM_OUT(NUM_OUT), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/evt_out_reg_tb.sv
`timescale 1ns/1ps
module evt_out_reg_tb;
   localparam int N = 6;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] set_stb = '0, clr_stb = '0, tgl_stb = '0;
   logic         halt_lo = 1'b0, halt_hi = 1'b0, halt_uni = 1'b0, unify = 1'b0;
   logic         wr_en = 1'b0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] rd_data;
   logic [N-1:0] out_lvl;
   logic         wr_reject;

   int total = 0;
   int bad = 0;
   bit done = 0;

   logic [N-1:0] exp_lvl = '0;
   logic         exp_rej = 1'b0;

   always #2.5 clk = ~clk;

   evt_out_reg u_dut (.*);

   function automatic logic permitted(input logic u, input logic lo, input logic hi, input logic un);
      return u ? un : (lo & hi);
   endfunction

   function automatic logic [N-1:0] next_lvl(input logic [N-1:0] cur, input logic load,
                                             input logic [N-1:0] wv, input logic [N-1:0] s,
                                             input logic [N-1:0] c, input logic [N-1:0] t);
      logic [N-1:0] r;
      if (load) return wv;
      for (int i = 0; i < N; i++) begin
         if (t[i] || (s[i] && c[i])) r[i] = ~cur[i];
         else if (s[i])              r[i] = 1'b1;
         else if (c[i])              r[i] = 1'b0;
         else                        r[i] = cur[i];
      end
      return r;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at falling edge, check at next falling edge
   task automatic step(input logic [N-1:0] s, input logic [N-1:0] c, input logic [N-1:0] t,
                       input logic lo, input logic hi, input logic un, input logic u,
                       input logic we, input logic [W-1:0] wd);
      logic ld;
      string tag;
      set_stb = s; clr_stb = c; tgl_stb = t;
      halt_lo = lo; halt_hi = hi; halt_uni = un; unify = u;
      wr_en = we; wr_data = wd;
      ld = we & permitted(u, lo, hi, un);
      if (ld && (s | c | t) != '0)   tag = "R7";
      else if (ld)                   tag = u ? "R3" : "R2";
      else if (we && (s|c|t) != '0)  tag = "R9";
      else if (we)                   tag = "R4";
      else if ((t | (s & c)) != '0)  tag = "R6";
      else                           tag = "R5";
      exp_lvl = next_lvl(exp_lvl, ld, wd[N-1:0], s, c, t);
      exp_rej = we & ~ld;
      @(negedge clk);
      chk(tag, W'(out_lvl), W'(exp_lvl));
      chk(we ? "R4" : tag, W'(wr_reject), W'(exp_rej));
      chk("R8", rd_data, W'(exp_lvl));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", W'(out_lvl), '0);
      chk("R1", rd_data, '0);
      chk("R1", W'(wr_reject), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", W'(out_lvl), '0);

      // directed corners
      step('0, '0, '0, 1, 1, 0, 0, 1, 32'hFFFF_FF2D);          // R2 split load, upper bits dropped
      step('0, '0, '0, 1, 0, 1, 0, 1, 32'h0000_0012);          // R4 split, hi running
      step('0, '0, '0, 0, 1, 1, 0, 1, 32'h0000_0012);          // R4 split, lo running
      step('0, '0, '0, 0, 0, 1, 1, 1, 32'h0000_0033);          // R3 unified, lo/hi running
      step('0, '0, '0, 1, 1, 0, 1, 1, 32'h0000_0000);          // R4 unified running
      step(6'b000011, 6'b110000, '0, 0, 0, 0, 0, 0, '0);       // R5 set/clr
      step(6'b000101, 6'b000101, '0, 0, 0, 0, 0, 0, '0);       // R6 set+clr flips
      step(6'b100000, 6'b010000, 6'b110000, 0, 0, 0, 0, 0, '0); // R6 toggle beats set/clr
      step('1, '0, '1, 1, 1, 0, 0, 1, 32'h0000_000A);          // R7 write beats events
      step(6'b000001, '0, 6'b000010, 0, 0, 0, 0, 1, 32'h3F);   // R9 events on rejected write

      for (int k = 0; k < 3000; k++) begin
         logic [N-1:0] s, c, t;
         s = N'($urandom) & N'($urandom);
         c = N'($urandom) & N'($urandom);
         t = N'($urandom) & N'($urandom) & N'($urandom);
         step(s, c, t, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 4) != 0,
              1'($urandom), ($urandom % 10) < 3, $urandom);
      end
      step('0, '0, '0, 0, 0, 0, 0, 0, '0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule